// File: doc/BRIEF.md
# Headset Jack Insertion Classifier

This controller watches the mechanical switch of a headset socket and a digitized microphone-pole sense line. It decides when an accessory has really been inserted or removed, and then tells a 3-pole plug from a 4-pole plug. The result appears on three registered status outputs: an active-low plugged flag, a pole-type flag and a key-state flag. Insertion must hold steady for much longer than removal before it is accepted. Once insertion is accepted, a short timed classification window follows.

All timing is counted in pulses of a millisecond tick-enable input, and every delay is a parameter. A bench or a faster system can therefore scale time by pulsing the tick more often. The jack switch, microphone sense and key sense arrive from analog comparators outside the block. Each of them passes through a two-flop synchronizer first.

When a 4-pole accessory is confirmed, the block raises a hand-off flag for the key-sensing logic. It then passes the synchronized key sense to the key output. Removal that has been debounced returns all outputs to the detached code from any state.

Top module: `jack_classifier`

## Requirements
- R1: After reset, the code on {plugN, poleThree, keyPress, keyEn} is 1,1,0,0, which is the detached code.
- R2: An insertion (jackSwN low) is accepted only after jackSwN has stayed low for INS_MS tick pulses. Any high level during that time discards the count, and the count starts again from zero at the next low.
- R3: A removal (jackSwN high) is accepted only after jackSwN has stayed high for REM_MS tick pulses. A shorter high pulse while an accessory is plugged leaves the outputs unchanged.
- R4: If micSense is high during the classification window, the code 0,0,0,1 results: plugged, 4-pole, no key, hand-off raised.
- R5: If DET_TICKS tick pulses pass in the classification window with micSense low, the code 0,1,0,0 results (3-pole). The outputs keep the detached code until that point.
- R6: Once an accessory has been classified as 3-pole, later activity on micSense does not change the outputs.
- R7: An accepted removal, whether from a classified state or from the classification window, restores the detached code 1,1,0,0.
- R8: keyEn is high only in the 4-pole state. keyPress follows the synchronized keySense only in that state and is 0 everywhere else.
- R9: The debounce and classification counters advance only on cycles where msTick is high. With msTick held low, no insertion is ever accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle millisecond time-base enable |
| jackSwN | input | 1 | Socket switch, asynchronous; 0 = inserted, 1 = empty |
| micSense | input | 1 | Microphone-pole load sense, asynchronous; 1 = 4-pole load present |
| keySense | input | 1 | Key comparator result, asynchronous; 1 = key held |
| plugN | output | 1 | 0 = accessory plugged, 1 = detached |
| poleThree | output | 1 | 1 = 3-pole (or detached), 0 = 4-pole |
| keyPress | output | 1 | 1 = key pressed on a 4-pole accessory |
| keyEn | output | 1 | Hand-off to the key-sensing logic; 1 in the 4-pole state |

## Verification
Two functions can act in the same cycle. The removal debounce can be running while a plug with a live microphone load is reclassified: a short high pulse on jackSwN in the 4-pole state sends the controller through the removal count and straight back into classification with micSense still high. The bench provokes this with a high pulse a few ticks shorter than REM_MS. It judges the case by requiring the 4-pole code to hold throughout, with no visible excursion to the detached or 3-pole code. A second collision pits the microphone sense against the expiry of the classification window. To test it, micSense is raised only after the window has closed on a 3-pole decision, and the bench requires that the 3-pole code remains.

// File: rtl/jack_pkg.sv
package jack_pkg;

  typedef enum logic [2:0] {
    ST_DETACHED,
    ST_INS_DEB,
    ST_CLASSIFY,
    ST_PLUG3,
    ST_PLUG4,
    ST_REM_DEB
  } jackState_t;

  typedef enum logic [1:0] {
    LIM_INS,
    LIM_REM,
    LIM_DET
  } limSel_t;

  typedef struct packed {
    logic    clrCnt;
    limSel_t limSel;
    logic    setDetached;
    logic    setThree;
    logic    setFour;
  } ctlStrb_t;

endpackage

// File: rtl/jack_sync.sv
module jack_sync #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta, stable;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta   <= RST_VAL[i];
        stable <= RST_VAL[i];
      end else begin
        meta   <= asyncIn[i];
        stable <= meta;
      end
    end
    assign syncOut[i] = stable;
  end

endmodule

// File: rtl/jack_datapath.sv
module jack_datapath
  import jack_pkg::*;
#(
  parameter int INS_MS    = 422,
  parameter int REM_MS    = 30,
  parameter int DET_TICKS = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     msTick,
  input  logic     keyS,
  input  ctlStrb_t strb,
  output logic     cntDone,
  output logic     plugN,
  output logic     poleThree,
  output logic     keyPress,
  output logic     keyEn
);

  localparam int MAX_AB  = (INS_MS > REM_MS) ? INS_MS : REM_MS;
  localparam int MAX_LIM = (MAX_AB > DET_TICKS) ? MAX_AB : DET_TICKS;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limVal;
  logic             keyEnNext;

  always_comb begin
    case (strb.limSel)
      LIM_INS: limVal = CNT_W'(INS_MS - 1);
      LIM_REM: limVal = CNT_W'(REM_MS - 1);
      default: limVal = CNT_W'(DET_TICKS - 1);
    endcase
  end

  assign cntDone = msTick && (cnt == limVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (strb.clrCnt) cnt <= '0;
    else if (msTick)      cnt <= cnt + 1'b1;
  end

  always_comb begin
    if (strb.setFour)                         keyEnNext = 1'b1;
    else if (strb.setThree || strb.setDetached) keyEnNext = 1'b0;
    else                                      keyEnNext = keyEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      plugN     <= 1'b1;
      poleThree <= 1'b1;
      keyEn     <= 1'b0;
      keyPress  <= 1'b0;
    end else begin
      if (strb.setDetached) begin
        plugN     <= 1'b1;
        poleThree <= 1'b1;
      end else if (strb.setThree) begin
        plugN     <= 1'b0;
        poleThree <= 1'b1;
      end else if (strb.setFour) begin
        plugN     <= 1'b0;
        poleThree <= 1'b0;
      end
      keyEn    <= keyEnNext;
      keyPress <= keyEnNext & keyS;
    end
  end

  // R8: a key press is only ever reported on a plugged 4-pole accessory
  p_key_needs_four_r8: assert property (@(posedge clk) disable iff (!rstN)
    keyPress |-> (!plugN && !poleThree && keyEn));

  // R7: detached code is always complete
  p_detached_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    plugN |-> (poleThree && !keyPress && !keyEn));

  // R9: counter frozen without a tick
  p_cnt_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!msTick && !strb.clrCnt) |=> $stable(cnt));

  // R2: counter never runs past the largest limit
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    cnt < CNT_W'(MAX_LIM));

  // R6: status flags move only under a strobe from control
  p_status_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setDetached || strb.setThree || strb.setFour)
      |=> ($stable(plugN) && $stable(poleThree)));

endmodule

// File: rtl/jack_ctrl.sv
module jack_ctrl
  import jack_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     jackS,
  input  logic     micS,
  input  logic     cntDone,
  output ctlStrb_t strb
);

  jackState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '{clrCnt: 1'b1, limSel: LIM_INS,
                  setDetached: 1'b0, setThree: 1'b0, setFour: 1'b0};
    case (state)
      ST_DETACHED: begin
        if (!jackS) stateNext = ST_INS_DEB;
      end
      ST_INS_DEB: begin
        strb.limSel = LIM_INS;
        if (jackS) begin
          stateNext = ST_DETACHED;
        end else if (cntDone) begin
          stateNext = ST_CLASSIFY;
        end else begin
          strb.clrCnt = 1'b0;
        end
      end
      ST_CLASSIFY: begin
        strb.limSel = LIM_DET;
        if (jackS) begin
          stateNext = ST_REM_DEB;
        end else if (micS) begin
          stateNext    = ST_PLUG4;
          strb.setFour = 1'b1;
        end else if (cntDone) begin
          stateNext     = ST_PLUG3;
          strb.setThree = 1'b1;
        end else begin
          strb.clrCnt = 1'b0;
        end
      end
      ST_PLUG3, ST_PLUG4: begin
        if (jackS) stateNext = ST_REM_DEB;
      end
      ST_REM_DEB: begin
        strb.limSel = LIM_REM;
        if (!jackS) begin
          stateNext = ST_CLASSIFY;
        end else if (cntDone) begin
          stateNext        = ST_DETACHED;
          strb.setDetached = 1'b1;
        end else begin
          strb.clrCnt = 1'b0;
        end
      end
      default: begin
        stateNext        = ST_DETACHED;
        strb.setDetached = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_DETACHED;
    else       state <= stateNext;
  end

  // R2: a high level during insertion debounce abandons it
  p_ins_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INS_DEB && jackS) |=> (state == ST_DETACHED));

  // R4: microphone load in the window confirms 4-pole
  p_mic_four_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CLASSIFY && !jackS && micS) |=> (state == ST_PLUG4));

  // R3: completed removal count lands in detached
  p_rem_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REM_DEB && jackS && cntDone) |=> (state == ST_DETACHED));

  // R6: a 3-pole decision is left only through removal
  p_three_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PLUG3 && !jackS) |=> (state == ST_PLUG3));

endmodule

// File: rtl/jack_classifier.sv
module jack_classifier
  import jack_pkg::*;
#(
  parameter int INS_MS    = 422,
  parameter int REM_MS    = 30,
  parameter int DET_TICKS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic jackSwN,
  input  logic micSense,
  input  logic keySense,
  output logic plugN,
  output logic poleThree,
  output logic keyPress,
  output logic keyEn
);

  logic [2:0] syncBits;
  logic       cntDone;
  ctlStrb_t   strb;

  jack_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({jackSwN, micSense, keySense}),
    .syncOut (syncBits)
  );

  jack_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .jackS   (syncBits[2]),
    .micS    (syncBits[1]),
    .cntDone (cntDone),
    .strb    (strb)
  );

  jack_datapath #(
    .INS_MS    (INS_MS),
    .REM_MS    (REM_MS),
    .DET_TICKS (DET_TICKS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .msTick    (msTick),
    .keyS      (syncBits[0]),
    .strb      (strb),
    .cntDone   (cntDone),
    .plugN     (plugN),
    .poleThree (poleThree),
    .keyPress  (keyPress),
    .keyEn     (keyEn)
  );

endmodule

// File: tb/jack_classifier_bench.sv
module jack_classifier_bench;

  localparam int CLK_PERIOD = 10;
  localparam int INS = 40;
  localparam int REM = 12;
  localparam int DET = 4;

  localparam logic [3:0] C_DET   = 4'b1100;
  localparam logic [3:0] C_THREE = 4'b0100;
  localparam logic [3:0] C_FOUR  = 4'b0001;
  localparam logic [3:0] C_KEY   = 4'b0011;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b1;
  logic jackSwN = 1'b1;
  logic micSense = 1'b0;
  logic keySense = 1'b0;
  logic plugN, poleThree, keyPress, keyEn;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  jack_classifier #(.INS_MS(INS), .REM_MS(REM), .DET_TICKS(DET)) u_jack_classifier (
    .clk(clk), .rstN(rstN), .msTick(msTick), .jackSwN(jackSwN),
    .micSense(micSense), .keySense(keySense),
    .plugN(plugN), .poleThree(poleThree), .keyPress(keyPress), .keyEn(keyEn)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {plugN, poleThree, keyPress, keyEn};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {plugN,poleThree,keyPress,keyEn} = %b, expected %b", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    check("R1 reset code", C_DET);
  endtask

  task automatic t_four_pole();
    micSense = 1'b1;
    jackSwN  = 1'b0;
    step(INS);
    check("R2 not yet accepted", C_DET);
    step(10);
    check("R4 four-pole code", C_FOUR);
    keySense = 1'b1;
    step(5);
    check("R8 key follows in four-pole", C_KEY);
    keySense = 1'b0;
    step(5);
    check("R8 key release", C_FOUR);
    jackSwN = 1'b1;
    step(REM - 4);
    jackSwN = 1'b0;
    step(REM + 10);
    check("R3 short high pulse ignored", C_FOUR);
    jackSwN = 1'b1;
    step(REM);
    check("R3 removal not yet accepted", C_FOUR);
    step(8);
    check("R7 removal from four-pole", C_DET);
    micSense = 1'b0;
  endtask

  task automatic t_three_pole();
    micSense = 1'b0;
    jackSwN  = 1'b0;
    step(INS + 5);
    check("R5 window still open", C_DET);
    step(4);
    check("R5 three-pole after window", C_THREE);
    micSense = 1'b1;
    step(10);
    check("R6 late mic sense ignored", C_THREE);
    keySense = 1'b1;
    step(5);
    check("R8 no key in three-pole", C_THREE);
    keySense = 1'b0;
    micSense = 1'b0;
    jackSwN  = 1'b1;
    step(REM + 8);
    check("R7 removal from three-pole", C_DET);
  endtask

  task automatic t_bounce();
    jackSwN = 1'b0;
    step(INS - 10);
    jackSwN = 1'b1;
    step(4);
    jackSwN = 1'b0;
    step(INS - 2);
    check("R2 bounce restarts count", C_DET);
    step(DET + 14);
    check("R2 accepted after restart", C_THREE);
    jackSwN = 1'b1;
    step(REM + 8);
    check("R7 detached after bounce test", C_DET);
  endtask

  task automatic t_tick_gate();
    msTick  = 1'b0;
    jackSwN = 1'b0;
    step(INS * 3);
    check("R9 no tick no progress", C_DET);
    msTick = 1'b1;
    step(INS + DET + 8);
    check("R9 progress with tick", C_THREE);
    jackSwN = 1'b1;
    step(REM + 8);
    check("R7 detached after tick test", C_DET);
  endtask

  task automatic t_remove_in_window();
    micSense = 1'b0;
    jackSwN  = 1'b0;
    step(INS + 4);
    jackSwN = 1'b1;
    step(REM + 8);
    check("R7 removal during classification", C_DET);
    step(DET + 4);
    check("R7 stays detached", C_DET);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(2);
    t_reset();
    t_four_pole();
    t_three_pole();
    t_bounce();
    t_tick_gate();
    t_remove_in_window();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual hung, expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule